// File: doc/BRIEF.md
# Reorder Buffer with Precise Exceptions

This block is a circular queue that holds the results of instructions that are still in flight. Instructions claim an entry at the tail in program order. They may then finish in any order, and they leave only from the head. Because of this, the architectural register state is always the state of some point in program order. A fault raised by an instruction is stored in its entry and acted on only when that entry reaches the head. At that point every in-flight entry is dropped and a handler request is raised for one cycle. A mispredicted branch removes every entry younger than the branch.

Four ports share the queue. Allocate reserves the tail entry for a destination register and returns its tag. Writeback stores a value and a fault flag for a tag. Lookup finds the youngest in-flight producer of a register; on a miss the caller reads the register file. Commit presents the head entry's register and value for writing to the register file.

Occupancy is tracked by a three-state machine: EMPTY, PARTIAL and FULL. An allocation without a commit moves EMPTY→PARTIAL or PARTIAL→FULL. A commit without an allocation moves FULL→PARTIAL or PARTIAL→EMPTY. A squash moves to PARTIAL or FULL, depending on how many entries remain. A fault flush moves any state to EMPTY. A cycle with both an allocation and a commit keeps the state.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: `empty`=1, `full`=0, and neither `commit_valid` nor `handler_req` is asserted.
- R2: `alloc_gnt` is asserted for a request only when the buffer is not full, no fault flush is taken and no squash is requested. Granted tags count upward modulo 8 from tag 0 after reset or flush.
- R3: `full` is 1 exactly when 8 entries are live, and `empty` is 1 exactly when none are live.
- R4: A writeback to a live tag marks that entry ready with the given value and fault flag. A writeback to a tag with no live entry, or one made in a flush cycle, has no effect.
- R5: The head entry commits in the same cycle in which it is live, ready and fault-free, unless a squash is requested. At most one entry commits per cycle, and a commit and an allocation may happen in the same cycle.
- R6: A live, ready head entry with its fault flag set raises `handler_req` for that cycle. In that cycle there is no commit and no allocation, and from the next cycle the buffer is empty.
- R7: Lookup reports a hit for the youngest live entry whose destination equals `look_reg`, giving its tag, ready bit and value. It reports no hit when no live entry names the register.
- R8: A squash naming a live tag keeps that entry and all older entries and removes every younger one. The next granted tag is the squash tag plus 1. Allocation and commit are held off in the squash cycle, and writebacks to surviving entries still take effect.
- R9: Entries commit in allocation order with the register and value of their own entry, whatever the order of their writebacks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Request for a new entry |
| alloc_dest | input | REG_W | Destination register of the new entry |
| alloc_gnt | output | 1 | Entry granted this cycle |
| alloc_tag | output | TAG_W | Tag of the granted entry (the tail) |
| wb_en | input | 1 | Writeback strobe |
| wb_tag | input | TAG_W | Entry being written back |
| wb_value | input | DATA_W | Result value |
| wb_fault | input | 1 | Instruction faulted |
| look_reg | input | REG_W | Register being looked up |
| look_hit | output | 1 | A live entry produces `look_reg` |
| look_tag | output | TAG_W | Tag of the youngest producer |
| look_ready | output | 1 | That producer has written back |
| look_value | output | DATA_W | That producer's value |
| squash_en | input | 1 | Branch mispredict recovery request |
| squash_tag | input | TAG_W | Tag of the mispredicted branch (must be live) |
| commit_valid | output | 1 | Head entry retires this cycle |
| commit_reg | output | REG_W | Register to update |
| commit_value | output | DATA_W | Value to write |
| handler_req | output | 1 | Faulting head: start the handler, buffer flushed |
| full | output | 1 | All entries live |
| empty | output | 1 | No entries live |

## Verification
The checker watches rules that hold on every cycle. A full buffer never grants. Commit and handler request never coincide. A handler request is always followed by an empty buffer and by no second request. Back-to-back grants carry consecutive tags. A squash cycle grants and commits nothing. Which entry lookup selects among several producers of a register, whether a writeback to a squashed tag was really dropped, and whether commits follow allocation order all depend on history. Only the bench's reference model can show these, as it tracks every entry through directed refill, squash and fault scenarios and a long random run.

// File: rtl/rob_pkg.sv
package rob_pkg;
    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_e;
endpackage

// File: rtl/rob_ptrs.sv
// Head/tail pointers, live-entry count and the occupancy state machine.
module rob_ptrs
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int TAG_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_fire,
    input  logic             commit_fire,
    input  logic             flush,
    input  logic             squash,
    input  logic [TAG_W-1:0] squash_tag,
    output logic [TAG_W-1:0] head,
    output logic [TAG_W-1:0] tail,
    output logic             full,
    output logic             empty
);
    localparam int CNT_W = TAG_W + 1;

    occ_state_e       state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [TAG_W-1:0] head_n, tail_n, sq_dist;

    assign sq_dist = squash_tag - head;

    // Next pointers and count
    always_comb begin
        head_n = head;
        tail_n = tail;
        cnt_n  = cnt;
        if (flush) begin
            head_n = '0;
            tail_n = '0;
            cnt_n  = '0;
        end else if (squash) begin
            tail_n = squash_tag + TAG_W'(1);
            cnt_n  = {1'b0, sq_dist} + CNT_W'(1);
        end else begin
            if (alloc_fire)  tail_n = tail + TAG_W'(1);
            if (commit_fire) head_n = head + TAG_W'(1);
            cnt_n = cnt + CNT_W'(alloc_fire) - CNT_W'(commit_fire);
        end
    end

    // Next state from the next occupancy
    always_comb begin
        if (cnt_n == '0)
            state_n = OCC_EMPTY;
        else if (cnt_n == CNT_W'(DEPTH))
            state_n = OCC_FULL;
        else
            state_n = OCC_PARTIAL;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= OCC_EMPTY;
            cnt   <= '0;
            head  <= '0;
            tail  <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            head  <= head_n;
            tail  <= tail_n;
        end
    end

    // Outputs
    always_comb begin
        full  = 1'b0;
        empty = 1'b0;
        unique case (state)
            OCC_EMPTY:   empty = 1'b1;
            OCC_PARTIAL: ;
            OCC_FULL:    full  = 1'b1;
            default:     ;
        endcase
    end
endmodule

// File: rtl/rob_store.sv
// Entry array: valid, ready, fault, destination, value per entry.
module rob_store #(
    parameter int DEPTH  = 8,
    parameter int TAG_W  = $clog2(DEPTH),
    parameter int REG_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          alloc_fire,
    input  logic [TAG_W-1:0]              tail,
    input  logic [REG_W-1:0]              alloc_dest,
    input  logic                          wb_en,
    input  logic [TAG_W-1:0]              wb_tag,
    input  logic [DATA_W-1:0]             wb_value,
    input  logic                          wb_fault,
    input  logic                          commit_fire,
    input  logic [TAG_W-1:0]              head,
    input  logic                          flush,
    input  logic                          squash,
    input  logic [TAG_W-1:0]              squash_tag,
    output logic [DEPTH-1:0]              ent_valid,
    output logic [DEPTH-1:0]              ent_done,
    output logic [DEPTH-1:0]              ent_fault,
    output logic [DEPTH-1:0][REG_W-1:0]   ent_dest,
    output logic [DEPTH-1:0][DATA_W-1:0]  ent_value
);
    logic [TAG_W-1:0] sq_age;
    assign sq_age = squash_tag - head;

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        localparam logic [TAG_W-1:0] IDX = TAG_W'(i);
        logic [TAG_W-1:0] age;
        logic             kill;

        assign age  = IDX - head;
        assign kill = squash && (age > sq_age);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_valid[i] <= 1'b0;
                ent_done[i]  <= 1'b0;
                ent_fault[i] <= 1'b0;
                ent_dest[i]  <= '0;
                ent_value[i] <= '0;
            end else if (flush) begin
                ent_valid[i] <= 1'b0;
            end else if (kill) begin
                ent_valid[i] <= 1'b0;
            end else begin
                if (alloc_fire && tail == IDX) begin
                    ent_valid[i] <= 1'b1;
                    ent_done[i]  <= 1'b0;
                    ent_fault[i] <= 1'b0;
                    ent_dest[i]  <= alloc_dest;
                end else if (wb_en && wb_tag == IDX && ent_valid[i]) begin
                    ent_done[i]  <= 1'b1;
                    ent_fault[i] <= wb_fault;
                    ent_value[i] <= wb_value;
                end
                if (commit_fire && head == IDX)
                    ent_valid[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rob_lookup.sv
// Youngest live producer of a register: walk from head to tail, last match wins.
module rob_lookup #(
    parameter int DEPTH  = 8,
    parameter int TAG_W  = $clog2(DEPTH),
    parameter int REG_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic [TAG_W-1:0]              head,
    input  logic [REG_W-1:0]              look_reg,
    input  logic [DEPTH-1:0]              ent_valid,
    input  logic [DEPTH-1:0]              ent_done,
    input  logic [DEPTH-1:0][REG_W-1:0]   ent_dest,
    input  logic [DEPTH-1:0][DATA_W-1:0]  ent_value,
    output logic                          look_hit,
    output logic [TAG_W-1:0]              look_tag,
    output logic                          look_ready,
    output logic [DATA_W-1:0]             look_value
);
    logic [TAG_W-1:0] idx;

    always_comb begin
        look_hit   = 1'b0;
        look_tag   = '0;
        look_ready = 1'b0;
        look_value = '0;
        idx        = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head + TAG_W'(k);
            if (ent_valid[idx] && ent_dest[idx] == look_reg) begin
                look_hit   = 1'b1;
                look_tag   = idx;
                look_ready = ent_done[idx];
                look_value = ent_value[idx];
            end
        end
    end
endmodule

// File: rtl/rob_core.sv
module rob_core #(
    parameter int DEPTH  = 8,
    parameter int TAG_W  = $clog2(DEPTH),
    parameter int REG_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_req,
    input  logic [REG_W-1:0]  alloc_dest,
    output logic              alloc_gnt,
    output logic [TAG_W-1:0]  alloc_tag,
    input  logic              wb_en,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [DATA_W-1:0] wb_value,
    input  logic              wb_fault,
    input  logic [REG_W-1:0]  look_reg,
    output logic              look_hit,
    output logic [TAG_W-1:0]  look_tag,
    output logic              look_ready,
    output logic [DATA_W-1:0] look_value,
    input  logic              squash_en,
    input  logic [TAG_W-1:0]  squash_tag,
    output logic              commit_valid,
    output logic [REG_W-1:0]  commit_reg,
    output logic [DATA_W-1:0] commit_value,
    output logic              handler_req,
    output logic              full,
    output logic              empty
);
    logic [TAG_W-1:0]             head, tail;
    logic [DEPTH-1:0]             ent_valid, ent_done, ent_fault;
    logic [DEPTH-1:0][REG_W-1:0]  ent_dest;
    logic [DEPTH-1:0][DATA_W-1:0] ent_value;
    logic head_ready, fault_take, commit_fire, alloc_fire, squash_do;

    // Head decisions: a fault outranks a squash, which outranks commit/alloc.
    assign head_ready  = ent_valid[head] && ent_done[head];
    assign fault_take  = head_ready && ent_fault[head];
    assign squash_do   = squash_en && !fault_take;
    assign commit_fire = head_ready && !ent_fault[head] && !squash_en;
    assign alloc_fire  = alloc_req && !full && !fault_take && !squash_en;

    assign alloc_gnt    = alloc_fire;
    assign alloc_tag    = tail;
    assign commit_valid = commit_fire;
    assign commit_reg   = ent_dest[head];
    assign commit_value = ent_value[head];
    assign handler_req  = fault_take;

    rob_ptrs #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_ptrs (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_fire (alloc_fire),
        .commit_fire(commit_fire),
        .flush      (fault_take),
        .squash     (squash_do),
        .squash_tag (squash_tag),
        .head       (head),
        .tail       (tail),
        .full       (full),
        .empty      (empty)
    );

    rob_store #(.DEPTH(DEPTH), .TAG_W(TAG_W), .REG_W(REG_W), .DATA_W(DATA_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_fire (alloc_fire),
        .tail       (tail),
        .alloc_dest (alloc_dest),
        .wb_en      (wb_en),
        .wb_tag     (wb_tag),
        .wb_value   (wb_value),
        .wb_fault   (wb_fault),
        .commit_fire(commit_fire),
        .head       (head),
        .flush      (fault_take),
        .squash     (squash_do),
        .squash_tag (squash_tag),
        .ent_valid  (ent_valid),
        .ent_done   (ent_done),
        .ent_fault  (ent_fault),
        .ent_dest   (ent_dest),
        .ent_value  (ent_value)
    );

    rob_lookup #(.DEPTH(DEPTH), .TAG_W(TAG_W), .REG_W(REG_W), .DATA_W(DATA_W)) u_look (
        .head      (head),
        .look_reg  (look_reg),
        .ent_valid (ent_valid),
        .ent_done  (ent_done),
        .ent_dest  (ent_dest),
        .ent_value (ent_value),
        .look_hit  (look_hit),
        .look_tag  (look_tag),
        .look_ready(look_ready),
        .look_value(look_value)
    );
endmodule

// File: rtl/rob_checker.sv
module rob_checker #(
    parameter int TAG_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_gnt,
    input logic [TAG_W-1:0] alloc_tag,
    input logic             squash_en,
    input logic             commit_valid,
    input logic             handler_req,
    input logic             full,
    input logic             empty
);
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !alloc_gnt);

    assert_tag_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(alloc_gnt) && alloc_gnt) |-> (alloc_tag == TAG_W'($past(alloc_tag) + 1'b1)));

    assert_flags_apart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    assert_empty_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (!commit_valid && !handler_req));

    assert_fault_no_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        handler_req |-> (!commit_valid && !alloc_gnt));

    assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        handler_req |=> (empty && !handler_req));

    assert_squash_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        squash_en |-> (!alloc_gnt && !commit_valid));
endmodule

bind rob_core rob_checker #(.TAG_W(TAG_W)) u_rob_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_gnt   (alloc_gnt),
    .alloc_tag   (alloc_tag),
    .squash_en   (squash_en),
    .commit_valid(commit_valid),
    .handler_req (handler_req),
    .full        (full),
    .empty       (empty)
);

// File: tb/rob_core_bench.sv
`timescale 1ns/1ps
module rob_core_bench;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_req = 1'b0;
    logic [4:0]  alloc_dest = '0;
    logic        alloc_gnt;
    logic [2:0]  alloc_tag;
    logic        wb_en = 1'b0;
    logic [2:0]  wb_tag = '0;
    logic [31:0] wb_value = '0;
    logic        wb_fault = 1'b0;
    logic [4:0]  look_reg = '0;
    logic        look_hit;
    logic [2:0]  look_tag;
    logic        look_ready;
    logic [31:0] look_value;
    logic        squash_en = 1'b0;
    logic [2:0]  squash_tag = '0;
    logic        commit_valid;
    logic [4:0]  commit_reg;
    logic [31:0] commit_value;
    logic        handler_req;
    logic        full, empty;

    always #10 clk = ~clk;

    rob_core u_rob_core (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(alloc_req), .alloc_dest(alloc_dest), .alloc_gnt(alloc_gnt), .alloc_tag(alloc_tag),
        .wb_en(wb_en), .wb_tag(wb_tag), .wb_value(wb_value), .wb_fault(wb_fault),
        .look_reg(look_reg), .look_hit(look_hit), .look_tag(look_tag),
        .look_ready(look_ready), .look_value(look_value),
        .squash_en(squash_en), .squash_tag(squash_tag),
        .commit_valid(commit_valid), .commit_reg(commit_reg), .commit_value(commit_value),
        .handler_req(handler_req), .full(full), .empty(empty)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // Reference model
    bit          mv[N];
    bit          md[N];
    bit          mf[N];
    int          mdst[N];
    logic [31:0] mval[N];
    int          mh = 0, mt = 0, mc = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int age_of(input int idx);
        return (idx - mh + N) % N;
    endfunction

    task automatic step(input bit areq, input int adest, input bit wen, input int wtag,
                        input logic [31:0] wval, input bit wflt, input bit sq,
                        input int sqt, input int lreg);
        bit hr, flt, ecom, egnt, found, erdy;
        int etag, sqa;
        logic [31:0] ev;
        @(negedge clk);
        alloc_req  = areq;  alloc_dest = 5'(adest);
        wb_en      = wen;   wb_tag     = 3'(wtag);  wb_value = wval; wb_fault = wflt;
        squash_en  = sq;    squash_tag = 3'(sqt);   look_reg = 5'(lreg);
        #1;
        hr   = mv[mh] && md[mh];
        flt  = hr && mf[mh];
        ecom = hr && !mf[mh] && !sq;
        egnt = areq && (mc < N) && !flt && !sq;
        chk(full  == (mc == N), "R3", "full",  full,  mc == N);
        chk(empty == (mc == 0), "R3", "empty", empty, mc == 0);
        chk(handler_req == flt, "R6", "handler_req", handler_req, flt);
        chk(commit_valid == ecom, "R5", "commit_valid", commit_valid, ecom);
        if (ecom) begin
            chk(commit_reg == 5'(mdst[mh]), "R9", "commit_reg", commit_reg, mdst[mh]);
            chk(commit_value == mval[mh], "R9", "commit_value", commit_value, mval[mh]);
        end
        chk(alloc_gnt == egnt, "R2 R8", "alloc_gnt", alloc_gnt, egnt);
        if (egnt) chk(alloc_tag == 3'(mt), "R2 R8", "alloc_tag", alloc_tag, mt);
        found = 1'b0; etag = 0; erdy = 1'b0; ev = '0;
        for (int k = 0; k < mc; k++) begin
            int ix = (mh + k) % N;
            if (mdst[ix] == lreg) begin
                found = 1'b1; etag = ix; erdy = md[ix]; ev = mval[ix];
            end
        end
        chk(look_hit == found, "R7", "look_hit", look_hit, found);
        if (found) begin
            chk(look_tag == 3'(etag), "R7", "look_tag", look_tag, etag);
            chk(look_ready == erdy, "R4", "look_ready", look_ready, erdy);
            if (erdy) chk(look_value == ev, "R4", "look_value", look_value, ev);
        end
        @(posedge clk);
        if (flt) begin
            for (int i = 0; i < N; i++) mv[i] = 1'b0;
            mh = 0; mt = 0; mc = 0;
        end else if (sq) begin
            sqa = age_of(sqt);
            if (wen && mv[wtag] && age_of(wtag) <= sqa) begin
                md[wtag] = 1'b1; mf[wtag] = wflt; mval[wtag] = wval;
            end
            for (int i = 0; i < N; i++) if (age_of(i) > sqa) mv[i] = 1'b0;
            mt = (sqt + 1) % N; mc = sqa + 1;
        end else begin
            if (wen && mv[wtag]) begin
                md[wtag] = 1'b1; mf[wtag] = wflt; mval[wtag] = wval;
            end
            if (ecom) begin
                mv[mh] = 1'b0; mh = (mh + 1) % N; mc--;
            end
            if (egnt) begin
                mv[mt] = 1'b1; md[mt] = 1'b0; mf[mt] = 1'b0; mdst[mt] = adest;
                mt = (mt + 1) % N; mc++;
            end
        end
    endtask

    task automatic idle(input int lreg);
        step(0, 0, 0, 0, 32'd0, 0, 0, 0, lreg);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int sqt, wt;
        void'($urandom(32'd4711));
        for (int i = 0; i < N; i++) begin
            mv[i] = 0; md[i] = 0; mf[i] = 0; mdst[i] = 0; mval[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #1;
        chk(empty == 1'b1, "R1", "empty after reset", empty, 1);
        chk(full == 1'b0, "R1", "full after reset", full, 0);
        chk(commit_valid == 1'b0 && handler_req == 1'b0, "R1", "commit/handler after reset",
            {commit_valid, handler_req}, 0);
        idle(3);
        // Fill with two interleaved producers, then one refused request
        for (int i = 0; i < 9; i++) step(1, (i % 2 == 0) ? 3 : 4, 0, 0, 32'd0, 0, 0, 0, 3);
        idle(4);
        // Out-of-order writebacks, in-order retirement
        step(0, 0, 1, 5, 32'h55, 0, 0, 0, 3);
        step(0, 0, 1, 2, 32'h22, 0, 0, 0, 4);
        step(0, 0, 1, 0, 32'h10, 0, 0, 0, 3);
        step(0, 0, 1, 1, 32'h11, 0, 0, 0, 3);
        repeat (3) idle(3);
        // Squash younger than tag 4 (live 3..7), then write to a removed tag
        step(1, 7, 1, 4, 32'h44, 0, 1, 4, 3);
        step(0, 0, 1, 6, 32'h66, 0, 0, 0, 4);
        step(1, 3, 0, 0, 32'd0, 0, 0, 0, 3);
        step(1, 3, 0, 0, 32'd0, 0, 0, 0, 3);
        idle(3);
        // Fault at the head flushes everything
        step(0, 0, 1, 3, 32'hBAD, 1, 0, 0, 3);
        idle(3);
        idle(3);
        // Constrained random
        for (int c = 0; c < 4000; c++) begin
            bit sq = (mc > 0) && ($urandom % 16 == 0);
            sqt = (mc > 0) ? (mh + int'($urandom % mc)) % N : 0;
            wt  = ($urandom % 4 == 0) ? int'($urandom % N)
                                      : ((mc > 0) ? (mh + int'($urandom % mc)) % N : 0);
            step($urandom % 3 != 0, int'($urandom % 4), $urandom % 2 == 0, wt,
                 $urandom, $urandom % 25 == 0, sq, sqt, int'($urandom % 5));
        end
        finish_run();
    end
endmodule